// File: doc/BRIEF.md
# Supply-Guarded Byte Memory Controller

This block is a synchronous model of a battery-backed static byte memory and its control logic. A host reaches the memory through three active-low strobes: chip enable, write enable and output enable. It also supplies an address and an 8-bit write bus. The read bus has a separate pad-enable output. When that enable is low, the pins are meant to float. Access times for address, chip enable and output enable, the recovery time after a write, and the output-disable delay after write enable falls are all parameters counted in clock cycles. Each strobe is sampled once per clock.

Three digitised supply flags come from an outside comparator. They are sorted from the highest threshold down: "run" (normal operation allowed), "trip" (write-protect threshold) and "switch" (main-versus-backup changeover). From these the block decides several things. It decides when all access is locked out, which power source feeds the cells, and whether the backup cell is still held in its factory isolation state. It also decides whether the stored contents can no longer be trusted. The default address width of 11 bits keeps the array small for elaboration. Setting it to 13 gives the full 8192-byte part.

Top module: `nvsram_ctrl`

## Requirements
- R1: With chip enable low, write enable high, output enable low and no lockout, `dout_en` goes high and `dout` carries the byte last committed at `addr`.
- R2: `dout_en` first rises at the clock edge numbered max(T_ADDR, T_CHIP, T_OUT)+1 when counted from the edge that first sees the latest of the address change, the chip-enable fall and the output-enable fall. Only the late arrivals count.
- R3: A write runs while both chip enable and write enable are low. It commits the address and data seen at its last clock edge with both low, at the first edge where either strobe is seen high.
- R4: No byte changes unless both strobes are low together. Write enable low alone leaves memory untouched.
- R5: A write whose strobes go low within T_REC cycles after a commit is ignored, and both strobes must be released before another write can start.
- R6: If the bus is driving and write enable falls, `dout_en` stays high for T_WDIS more edges and drops at edge T_WDIS+1.
- R7: When the trip flag is low, all strobes are ignored, `write_locked` is high at the next edge, and `dout_en` is low at the next edge.
- R8: Once locked, the block stays locked while trip is high and run is low. It unlocks at the first edge that sees run and trip both high.
- R9: A write in progress when the trip flag drops is abandoned, and its target byte keeps its old value.
- R10: `on_main` is high whenever the switch flag is high. `on_backup` is high when switch is low and the seal is broken. Both are low when switch is low and the cell is still sealed.
- R11: `cell_sealed` is high after reset and clears at the first edge that sees trip high. It does not return high before the next reset.
- R12: `contents_lost` sets at an edge that sees switch low while the cell is sealed. It stays set until reset and is never set by a supply dip after unsealing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read bus pad enable; low means high impedance |
| vf_trip | input | 1 | Supply above the write-protect threshold |
| vf_switch | input | 1 | Supply above the backup changeover level |
| vf_run | input | 1 | Supply above the normal-operation level |
| on_main | output | 1 | Cells fed from main supply |
| on_backup | output | 1 | Cells fed from the backup cell |
| write_locked | output | 1 | All access locked out |
| cell_sealed | output | 1 | Backup cell still isolated |
| contents_lost | output | 1 | Supply lost while sealed; contents invalid |

## Verification
The assertions assume the supply flags are nested: run implies trip, and trip implies switch. A supply may fall or rise through the levels, but a higher flag never reads high while a lower one reads low. They also assume address and data are held stable across a write. The stimulus always moves the flags in threshold order. It changes strobes, address and data only just after a rising edge. Within a write, the bench alters the write data only while both strobes are low, and that change is what the last-value check relies on.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_BATT = 2'd2
  } pwr_src_e;
endpackage

// File: rtl/nvs_age.sv
// Saturating counter of consecutive cycles a condition has held.
module nvs_age #(
  parameter int LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic ready
);
  localparam int W = $clog2(LIMIT + 1) + 1;
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] age_q, age_d;

  always_comb begin
    if (!active)          age_d = '0;
    else if (restart)     age_d = W'(1);
    else if (age_q >= LIM) age_d = age_q;
    else                  age_d = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assign ready = (age_q >= LIM);
endmodule

// File: rtl/nvs_supply.sv
// Supply-level decisions: lockout hysteresis, power source, seal, loss flag.
module nvs_supply
  import nvs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     vf_trip,
  input  logic     vf_switch,
  input  logic     vf_run,
  output logic     block,
  output logic     locked,
  output logic     sealed,
  output logic     lost,
  output pwr_src_e src
);
  logic     locked_d, sealed_d, lost_d;
  pwr_src_e src_d;

  always_comb begin
    block    = locked | ~vf_trip;
    locked_d = locked;
    if (!vf_trip)    locked_d = 1'b1;
    else if (vf_run) locked_d = 1'b0;
    sealed_d = sealed & ~vf_trip;
    lost_d   = lost | (~vf_switch & sealed);
    if (vf_switch)   src_d = SRC_MAIN;
    else if (!sealed) src_d = SRC_BATT;
    else             src_d = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      sealed <= 1'b1;
      lost   <= 1'b0;
      src    <= SRC_NONE;
    end else begin
      locked <= locked_d;
      sealed <= sealed_d;
      lost   <= lost_d;
      src    <= src_d;
    end
  end
endmodule

// File: rtl/nvs_access.sv
// Strobe sequencing: read timing, output drive, write window, recovery.
module nvs_access #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int T_ADDR = 3,
  parameter int T_CHIP = 2,
  parameter int T_OUT  = 1,
  parameter int T_REC  = 4,
  parameter int T_WDIS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              drive,
  output logic              rd_load,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int REC_W = $clog2(T_REC + 1);

  logic              aa_rdy, ce_rdy, oe_rdy, wdis_rdy;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_chg;
  logic              drive_d;
  logic              wa, start, capture, rec_busy;
  logic              in_wr_q, in_wr_d, armed_q, armed_d;
  logic [REC_W-1:0]  rec_q, rec_d;

  assign addr_chg = (addr != addr_q);

  nvs_age #(.LIMIT(T_ADDR)) u_age_addr (
    .clk(clk), .rst_n(rst_n), .active(1'b1), .restart(addr_chg), .ready(aa_rdy));
  nvs_age #(.LIMIT(T_CHIP)) u_age_chip (
    .clk(clk), .rst_n(rst_n), .active(~ce_n), .restart(1'b0), .ready(ce_rdy));
  nvs_age #(.LIMIT(T_OUT)) u_age_out (
    .clk(clk), .rst_n(rst_n), .active(~oe_n), .restart(1'b0), .ready(oe_rdy));
  nvs_age #(.LIMIT(T_WDIS)) u_age_wdis (
    .clk(clk), .rst_n(rst_n), .active(~we_n), .restart(1'b0), .ready(wdis_rdy));

  always_comb begin
    rd_load  = ~block & ~ce_n & we_n & ~oe_n & aa_rdy & ce_rdy & oe_rdy;
    drive_d  = rd_load | (drive & ~block & ~ce_n & ~oe_n & ~we_n & ~wdis_rdy);

    wa       = ~ce_n & ~we_n;
    rec_busy = (rec_q != '0);
    start    = wa & armed_q & ~rec_busy & ~block & ~in_wr_q;
    capture  = ~block & wa & (in_wr_q | start);
    wr_commit = in_wr_q & ~wa & ~block;

    if (block)        in_wr_d = 1'b0;
    else if (in_wr_q) in_wr_d = wa;
    else              in_wr_d = start;

    if (wr_commit)     rec_d = REC_W'(T_REC);
    else if (rec_busy) rec_d = rec_q - 1'b1;
    else               rec_d = '0;

    if (ce_n | we_n)            armed_d = 1'b1;
    else if (rec_busy | block)  armed_d = 1'b0;
    else                        armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      drive   <= 1'b0;
      in_wr_q <= 1'b0;
      armed_q <= 1'b0;
      rec_q   <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      addr_q  <= addr;
      drive   <= drive_d;
      in_wr_q <= in_wr_d;
      armed_q <= armed_d;
      rec_q   <= rec_d;
      if (capture) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int T_ADDR = 3,
  parameter int T_CHIP = 2,
  parameter int T_OUT  = 1,
  parameter int T_REC  = 4,
  parameter int T_WDIS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic              vf_trip,
  input  logic              vf_switch,
  input  logic              vf_run,
  output logic              on_main,
  output logic              on_backup,
  output logic              write_locked,
  output logic              cell_sealed,
  output logic              contents_lost
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              block, rd_load, wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  pwr_src_e          src;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  nvs_supply u_supply (
    .clk(clk), .rst_n(rst_int_n),
    .vf_trip(vf_trip), .vf_switch(vf_switch), .vf_run(vf_run),
    .block(block), .locked(write_locked), .sealed(cell_sealed),
    .lost(contents_lost), .src(src));

  nvs_access #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ADDR(T_ADDR), .T_CHIP(T_CHIP),
    .T_OUT(T_OUT), .T_REC(T_REC), .T_WDIS(T_WDIS)
  ) u_access (
    .clk(clk), .rst_n(rst_int_n), .block(block),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .drive(dout_en), .rd_load(rd_load), .wr_commit(wr_commit),
    .wr_addr(wr_addr), .wr_data(wr_data));

  always_ff @(posedge clk) begin
    if (wr_commit) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   dout <= '0;
    else if (rd_load) dout <= mem[addr];
  end

  assign on_main   = (src == SRC_MAIN);
  assign on_backup = (src == SRC_BATT);
endmodule

// File: rtl/nvsram_chk.sv
module nvsram_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic vf_trip,
  input logic vf_run,
  input logic dout_en,
  input logic write_locked,
  input logic cell_sealed,
  input logic on_main,
  input logic on_backup,
  input logic contents_lost
);
  a_r1_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(!ce_n && we_n && !oe_n));

  a_r7_quiet_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    write_locked |-> !dout_en);

  a_r8_unlock_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_locked) |-> $past(vf_run && vf_trip));

  a_r10_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({on_main, on_backup}));

  a_r10_backup_unsealed: assert property (@(posedge clk) disable iff (!rst_n)
    on_backup |-> !cell_sealed);

  a_r11_seal_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_sealed |=> !cell_sealed);

  a_r11_unseal_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cell_sealed) |-> $past(vf_trip));

  a_r12_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    contents_lost |=> contents_lost);
endmodule

bind nvsram_ctrl nvsram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .vf_trip(vf_trip), .vf_run(vf_run), .dout_en(dout_en),
  .write_locked(write_locked), .cell_sealed(cell_sealed),
  .on_main(on_main), .on_backup(on_backup), .contents_lost(contents_lost));

// File: tb/nvsram_ctrl_tb.sv
`timescale 1ns/1ps
module nvsram_ctrl_tb;
  localparam int AW = 11, DW = 8;
  localparam int TA = 3, TC = 2, TO = 1, TR = 4, TW = 2;
  localparam int TMAX = (TA > TC) ? ((TA > TO) ? TA : TO) : ((TC > TO) ? TC : TO);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ce_n, we_n, oe_n, vf_trip, vf_switch, vf_run;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en, on_main, on_backup, write_locked, cell_sealed, contents_lost;

  nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_ADDR(TA), .T_CHIP(TC), .T_OUT(TO),
                .T_REC(TR), .T_WDIS(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .vf_trip(vf_trip), .vf_switch(vf_switch), .vf_run(vf_run),
    .on_main(on_main), .on_backup(on_backup), .write_locked(write_locked),
    .cell_sealed(cell_sealed), .contents_lost(contents_lost));

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] model [1 << AW];
  logic [AW-1:0] pool [12];
  logic exp_seal, exp_lost;

  function automatic logic next_lost(logic prev, logic sw, logic sealed);
    return prev | (~sw & sealed);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, bit we_first, bit we_up);
    addr = a; din = d;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    tick(1);
    ce_n = 1'b0; we_n = 1'b0;
    tick(2);
    if (we_up) we_n = 1'b1; else ce_n = 1'b1;
    tick(1);
    idle();
    tick(TR + 2);
    model[a] = d;
  endtask

  task automatic attempt(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    tick(3);
    idle();
    tick(TR + 2);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    tick(TMAX + 2);
    chk({req, " drive"}, dout_en, 1);
    chk({req, " data"}, dout, model[a]);
    idle();
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; idle(); addr = '0; din = '0;
    vf_trip = 1'b0; vf_switch = 1'b0; vf_run = 1'b0;
    for (int i = 0; i < 12; i++) pool[i] = AW'(i * 100 + $urandom_range(0, 99));
    tick(3);
    // R11 / R7 reset state
    chk("R11 sealed at reset", cell_sealed, 1);
    chk("R7 locked at reset", write_locked, 1);
    chk("R7 no drive at reset", dout_en, 0);
    chk("R12 not lost at reset", contents_lost, 0);
    exp_seal = 1'b1; exp_lost = 1'b0;
    rst_n = 1'b1;
    tick(4);
    exp_lost = next_lost(exp_lost, vf_switch, exp_seal);
    chk("R12 lost while sealed", contents_lost, exp_lost);
    chk("R10 no source while sealed", {on_main, on_backup}, 2'b00);
    vf_switch = 1'b1; tick(2);
    chk("R10 main source", {on_main, on_backup}, 2'b10);
    chk("R11 still sealed below trip", cell_sealed, 1);
    vf_trip = 1'b1; tick(2);
    chk("R11 unseal on trip", cell_sealed, 0);
    chk("R8 locked until run", write_locked, 1);
    chk("R12 lost sticky", contents_lost, 1);
    vf_run = 1'b1; tick(2);
    chk("R8 unlock on run", write_locked, 0);

    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(5);
    chk("R11 unseal after second reset", cell_sealed, 0);
    chk("R12 clear after reset", contents_lost, 0);
    chk("R8 unlocked with power good", write_locked, 0);

    // R3 both strobe orderings
    do_write(pool[0], 8'hA5, 1'b1, 1'b1);
    do_write(pool[1], 8'h3C, 1'b0, 1'b0);
    do_read(pool[0], "R3 write we first");
    do_read(pool[1], "R3 write ce first");

    // R2 address-limited latency
    addr = pool[1]; tick(2);
    addr = pool[0]; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    tick(TMAX);
    chk("R2 not before limit", dout_en, 0);
    tick(1);
    chk("R2 drive at limit", dout_en, 1);
    chk("R1 read data", dout, model[pool[0]]);
    idle(); tick(1);
    // R2 chip-enable-limited latency
    addr = pool[1]; oe_n = 1'b0; tick(5);
    ce_n = 1'b0; tick(TC);
    chk("R2 ce not before limit", dout_en, 0);
    tick(1);
    chk("R2 ce drive at limit", dout_en, 1);
    idle(); tick(1);

    // random traffic
    for (int i = 0; i < 8; i++) do_write(pool[i], 8'($urandom), 1'($urandom), 1'($urandom));
    for (int i = 0; i < 40; i++) begin
      int k = $urandom_range(0, 7);
      if ($urandom_range(0, 1) == 1) do_write(pool[k], 8'($urandom), 1'($urandom), 1'($urandom));
      else do_read(pool[k], "R1 random read");
    end

    // R3 last value wins
    addr = pool[2]; din = 8'h11; ce_n = 1'b0; we_n = 1'b0; tick(2);
    din = 8'h22; tick(1); idle(); tick(TR + 2);
    model[pool[2]] = 8'h22;
    do_read(pool[2], "R3 last value");

    // R4 write enable alone
    addr = pool[3]; din = ~model[pool[3]]; we_n = 1'b0; tick(3); idle(); tick(2);
    do_read(pool[3], "R4 we alone");

    // R5 recovery
    addr = pool[4]; din = 8'h5A; ce_n = 1'b0; we_n = 1'b0; tick(2);
    idle(); tick(1);
    din = 8'hC3; ce_n = 1'b0; we_n = 1'b0; tick(2);
    idle(); tick(TR + 3);
    model[pool[4]] = 8'h5A;
    do_read(pool[4], "R5 early write ignored");

    // R6 output disable after write enable falls
    addr = pool[5]; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tick(TMAX + 2);
    din = model[pool[5]]; we_n = 1'b0; tick(TW);
    chk("R6 still driving", dout_en, 1);
    tick(1);
    chk("R6 off after delay", dout_en, 0);
    idle(); tick(TR + 2);

    // R7 lockout
    addr = pool[6]; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tick(TMAX + 2);
    vf_run = 1'b0; vf_trip = 1'b0; tick(1);
    chk("R7 drive off", dout_en, 0);
    chk("R7 locked", write_locked, 1);
    idle(); tick(1);
    attempt(pool[6], ~model[pool[6]]);
    vf_trip = 1'b1; tick(2);
    chk("R8 stays locked", write_locked, 1);
    attempt(pool[6], ~model[pool[6]]);
    vf_run = 1'b1; tick(2);
    chk("R8 unlocked", write_locked, 0);
    do_read(pool[6], "R7 writes ignored");

    // R9 write abandoned by lockout
    addr = pool[7]; din = ~model[pool[7]]; ce_n = 1'b0; we_n = 1'b0; tick(2);
    vf_run = 1'b0; vf_trip = 1'b0; tick(1);
    idle(); tick(1);
    vf_trip = 1'b1; vf_run = 1'b1; tick(3);
    do_read(pool[7], "R9 aborted write");

    // R10 / R12 dip after unsealing
    vf_run = 1'b0; vf_trip = 1'b0; tick(1); vf_switch = 1'b0; tick(2);
    chk("R10 backup source", {on_main, on_backup}, 2'b01);
    chk("R12 no loss when unsealed", contents_lost, 0);
    chk("R11 stays unsealed", cell_sealed, 0);
    vf_switch = 1'b1; tick(1); vf_trip = 1'b1; tick(1); vf_run = 1'b1; tick(3);
    chk("R10 main again", {on_main, on_backup}, 2'b10);
    do_read(pool[0], "R10 retained");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule